// File: doc/BRIEF.md
# USB OTG Session Request Sequencer

This block runs the B-device side of a USB On-The-Go session request. When software raises a start request, the block confirms that the previous session is over. VBUS must read below the session-end level, and both data lines must have stayed low for a set number of millisecond ticks. While it waits for VBUS to decay, it enables the VBUS discharge resistor.

Once that precondition holds, the block makes two pulses in a fixed order. It first drives the D+ pull-up for a set number of milliseconds. It then drives the VBUS charge path for a second set length. During the VBUS pulse the session-valid comparator is ignored. After the pulse the block releases every drive and waits for the A-device to restore VBUS. When session valid is seen, it turns the D+ pull-up back on to reconnect and reports completion. If session valid does not arrive within a configurable timeout, it releases all drives and reports an error.

All timing is counted in pulses of a 1 ms tick input, so the block runs from any system clock. The comparator thresholds and the analogue drive paths sit outside the block.

Top module: `sess_req_seq`

## Requirements
- R1: After reset all six outputs are low and the block is idle.
- R2: A start request from idle makes busy high on the next clock edge, and no pulse drive starts until the precondition is met.
- R3: While checking the precondition, VBUS discharge is high exactly when the session-end input is low. It is low in every other state.
- R4: The precondition is the session-end input high together with D+ and D- both low for IDLE_MS consecutive ticks. A high level on either line restarts that count from zero.
- R5: Once the precondition holds, the D+ pull-up is driven alone until the DP_PULSE_MS-th tick after entry.
- R6: The VBUS charge output follows the D+ pulse and stays high until the VBUS_PULSE_MS-th tick after entry. Session valid has no effect during this pulse.
- R7: After the VBUS pulse all drives are low. Session valid then ends the sequence with done high, busy low, and the D+ pull-up high.
- R8: If TIMEOUT_MS ticks pass after the VBUS pulse without session valid, error goes high, busy goes low, and all drives are low.
- R9: A start request while done or error is shown clears that status and begins a new precondition check.
- R10: At most one of the pull-up, discharge and charge outputs is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a new session |
| sess_end_i | input | 1 | VBUS is below the session-end level |
| sess_vld_i | input | 1 | VBUS is above the session-valid level |
| dp_i | input | 1 | D+ line level |
| dm_i | input | 1 | D- line level |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| dp_pullup_o | output | 1 | Enable the D+ pull-up |
| vbus_dis_o | output | 1 | Enable the VBUS discharge resistor |
| vbus_chg_o | output | 1 | Enable the VBUS charge path |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Session request completed, link reconnected |
| err_o | output | 1 | Session valid not seen before timeout |

## Verification
The hardest case to reach is the line-idle restart while the precondition is otherwise met. Session end is already high and a line goes high partway through the idle count, so the block must neither start the pulse early nor keep the partial count. The stimulus holds session end high, lets one tick pass, raises D- for one cycle and then ticks again. It checks that the D+ pulse starts only after a full fresh idle window. The same care applies to the session-valid pulse that arrives in the middle of the VBUS pulse, which must not cut the pulse short.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_DPULSE = 3'd2,
    ST_VPULSE = 3'd3,
    ST_WAIT   = 3'd4,
    ST_DONE   = 3'd5,
    ST_FAIL   = 3'd6
  } sr_state_e;

endpackage

// File: rtl/sr_tick_count.sv
module sr_tick_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_SAT = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = clr_i | (tick_i & (cnt_q != CNT_SAT));

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sr_idle_mon.sv
module sr_idle_mon #(
  parameter int IDLE_MS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_i,
  input  logic dm_i,
  input  logic tick_i,
  output logic idle_o
);

  localparam int IW = $clog2(IDLE_MS + 1);
  localparam logic [IW-1:0] IDLE_FULL = IW'(IDLE_MS);

  logic          line_hi;
  logic [IW-1:0] run_q;
  logic [IW-1:0] run_d;
  logic          run_en;

  assign line_hi = dp_i | dm_i;
  assign run_en  = line_hi | (tick_i & (run_q != IDLE_FULL));

  always_comb begin
    if (line_hi) run_d = '0;
    else         run_d = run_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end

  assign idle_o = (run_q == IDLE_FULL) & ~line_hi;

endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import sr_pkg::*;
#(
  parameter int DP_PULSE_MS   = 7,
  parameter int VBUS_PULSE_MS = 10,
  parameter int TIMEOUT_MS    = 5000,
  parameter int PW            = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          sess_end_i,
  input  logic          sess_vld_i,
  input  logic          idle_i,
  input  logic          tick_i,
  input  logic [PW-1:0] phase_i,
  output logic          phase_clr_o,
  output logic          dp_pullup_o,
  output logic          vbus_dis_o,
  output logic          vbus_chg_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam logic [PW-1:0] DP_LAST = PW'(DP_PULSE_MS - 1);
  localparam logic [PW-1:0] VB_LAST = PW'(VBUS_PULSE_MS - 1);
  localparam logic [PW-1:0] TO_LAST = PW'(TIMEOUT_MS - 1);

  sr_state_e state_q;
  sr_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start_i) state_d = ST_CHECK;
      ST_CHECK:  if (sess_end_i && idle_i) state_d = ST_DPULSE;
      ST_DPULSE: if (tick_i && (phase_i == DP_LAST)) state_d = ST_VPULSE;
      ST_VPULSE: if (tick_i && (phase_i == VB_LAST)) state_d = ST_WAIT;
      ST_WAIT: begin
        if (sess_vld_i)                             state_d = ST_DONE;
        else if (tick_i && (phase_i == TO_LAST))    state_d = ST_FAIL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign phase_clr_o = (state_d != state_q);

  always_comb begin
    dp_pullup_o = 1'b0;
    vbus_dis_o  = 1'b0;
    vbus_chg_o  = 1'b0;
    busy_o      = 1'b0;
    done_o      = 1'b0;
    err_o       = 1'b0;
    unique case (state_q)
      ST_CHECK: begin
        busy_o     = 1'b1;
        vbus_dis_o = ~sess_end_i;
      end
      ST_DPULSE: begin
        busy_o      = 1'b1;
        dp_pullup_o = 1'b1;
      end
      ST_VPULSE: begin
        busy_o     = 1'b1;
        vbus_chg_o = 1'b1;
      end
      ST_WAIT: busy_o = 1'b1;
      ST_DONE: begin
        done_o      = 1'b1;
        dp_pullup_o = 1'b1;
      end
      ST_FAIL: err_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sess_req_seq.sv
module sess_req_seq #(
  parameter int IDLE_MS       = 2,
  parameter int DP_PULSE_MS   = 7,
  parameter int VBUS_PULSE_MS = 10,
  parameter int TIMEOUT_MS    = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sess_end_i,
  input  logic sess_vld_i,
  input  logic dp_i,
  input  logic dm_i,
  input  logic tick_ms_i,
  output logic dp_pullup_o,
  output logic vbus_dis_o,
  output logic vbus_chg_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);

  localparam int PULSE_MAX = (DP_PULSE_MS > VBUS_PULSE_MS) ? DP_PULSE_MS : VBUS_PULSE_MS;
  localparam int SPAN_MAX  = (TIMEOUT_MS > PULSE_MAX) ? TIMEOUT_MS : PULSE_MAX;
  localparam int PW        = $clog2(SPAN_MAX + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          idle_ok;
  logic          phase_clr;
  logic [PW-1:0] phase_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  sr_idle_mon #(
    .IDLE_MS (IDLE_MS)
  ) u_idle (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .dp_i   (dp_i),
    .dm_i   (dm_i),
    .tick_i (tick_ms_i),
    .idle_o (idle_ok)
  );

  sr_tick_count #(
    .W (PW)
  ) u_phase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (phase_clr),
    .tick_i (tick_ms_i),
    .cnt_o  (phase_cnt)
  );

  sr_ctrl #(
    .DP_PULSE_MS   (DP_PULSE_MS),
    .VBUS_PULSE_MS (VBUS_PULSE_MS),
    .TIMEOUT_MS    (TIMEOUT_MS),
    .PW            (PW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .sess_end_i  (sess_end_i),
    .sess_vld_i  (sess_vld_i),
    .idle_i      (idle_ok),
    .tick_i      (tick_ms_i),
    .phase_i     (phase_cnt),
    .phase_clr_o (phase_clr),
    .dp_pullup_o (dp_pullup_o),
    .vbus_dis_o  (vbus_dis_o),
    .vbus_chg_o  (vbus_chg_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

endmodule

// File: rtl/sess_req_seq_chk.sv
module sess_req_seq_chk (
  input logic clk,
  input logic rst_int_n,
  input logic sess_end_i,
  input logic tick_ms_i,
  input logic dp_pullup_o,
  input logic vbus_dis_o,
  input logic vbus_chg_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);

  a_r10_one_drive: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({dp_pullup_o, vbus_dis_o, vbus_chg_o}));

  a_r3_dis_only_above_end: assert property (@(posedge clk) disable iff (!rst_int_n)
    vbus_dis_o |-> (!sess_end_i && busy_o));

  a_r6_chg_after_dp: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(vbus_chg_o) |-> $past(dp_pullup_o));

  a_r6_chg_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vbus_chg_o && !tick_ms_i) |=> vbus_chg_o);

  a_r5_dp_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dp_pullup_o && busy_o && !tick_ms_i) |=> dp_pullup_o);

  a_r7_done_reconnected: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (dp_pullup_o && !busy_o && !err_o));

  a_r8_err_released: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_o |-> (!dp_pullup_o && !vbus_dis_o && !vbus_chg_o && !busy_o));

endmodule

bind sess_req_seq sess_req_seq_chk u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .sess_end_i  (sess_end_i),
  .tick_ms_i   (tick_ms_i),
  .dp_pullup_o (dp_pullup_o),
  .vbus_dis_o  (vbus_dis_o),
  .vbus_chg_o  (vbus_chg_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/sess_req_seq_test.sv
module sess_req_seq_test;

  logic clk;
  logic rst_n;
  logic start_i, sess_end_i, sess_vld_i, dp_i, dm_i, tick_ms_i;
  logic dp_pullup_o, vbus_dis_o, vbus_chg_o, busy_o, done_o, err_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  sess_req_seq #(
    .IDLE_MS       (2),
    .DP_PULSE_MS   (3),
    .VBUS_PULSE_MS (4),
    .TIMEOUT_MS    (20)
  ) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .sess_end_i  (sess_end_i),
    .sess_vld_i  (sess_vld_i),
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .tick_ms_i   (tick_ms_i),
    .dp_pullup_o (dp_pullup_o),
    .vbus_dis_o  (vbus_dis_o),
    .vbus_chg_o  (vbus_chg_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Inputs {start, sess_end, sess_vld, dp, dm, tick}
  // Outputs {pullup, discharge, charge, busy, done, err}
  localparam logic [11:0] VEC [0:16] = '{
    12'b100000_010100,  // R2 start, R3 discharge while above end
    12'b000001_010100,  // R3 idle tick 1
    12'b000001_010100,  // R3 idle tick 2
    12'b010100_000100,  // R4 D+ high restarts idle count
    12'b010001_000100,  // R4 tick 1
    12'b010001_000100,  // R4 tick 2
    12'b010000_100100,  // R5 pull-up pulse begins
    12'b010001_100100,  // R5
    12'b010001_100100,  // R5
    12'b010001_001100,  // R6 third tick ends D+ pulse
    12'b011001_001100,  // R6 session valid ignored
    12'b011001_001100,  // R6
    12'b011001_001100,  // R6
    12'b010001_000100,  // R7 fourth tick ends charge
    12'b010000_000100,  // R7 waiting
    12'b011000_100010,  // R7 session valid -> done
    12'b010000_100010   // R7 done held
  };

  function automatic string vec_req(int i);
    if (i < 3)  return "R3";
    if (i < 6)  return "R4";
    if (i < 9)  return "R5";
    if (i < 13) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {dp_pullup_o, vbus_dis_o, vbus_chg_o, busy_o, done_o, err_o};
  endfunction

  task automatic step(logic [5:0] in);
    {start_i, sess_end_i, sess_vld_i, dp_i, dm_i, tick_ms_i} = in;
    @(negedge clk);
  endtask

  task automatic do_reset();
    {start_i, sess_end_i, sess_vld_i, dp_i, dm_i, tick_ms_i} = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    check("R1", outs(), 6'b000000);

    for (int i = 0; i < 17; i++) begin
      step(VEC[i][11:6]);
      check(vec_req(i), outs(), VEC[i][5:0]);
    end

    // R9 restart from done
    step(6'b110000);
    check("R9", outs(), 6'b000100);

    // Directed: D- restart, then timeout
    do_reset();
    step(6'b110000);
    check("R2", outs(), 6'b000100);
    step(6'b010001);
    step(6'b010010);
    check("R4", outs(), 6'b000100);
    step(6'b010001);
    step(6'b010001);
    check("R4", outs(), 6'b000100);
    step(6'b010000);
    check("R4", outs(), 6'b100100);
    for (int i = 0; i < 3; i++) step(6'b010001);
    check("R6", outs(), 6'b001100);
    for (int i = 0; i < 4; i++) step(6'b010001);
    check("R7", outs(), 6'b000100);
    for (int i = 0; i < 19; i++) step(6'b010001);
    check("R8", outs(), 6'b000100);
    step(6'b010001);
    check("R8", outs(), 6'b000001);
    step(6'b010000);
    check("R8", outs(), 6'b000001);

    // R9 restart from error, lines already idle
    step(6'b110000);
    check("R9", outs(), 6'b000100);
    step(6'b010000);
    check("R9", outs(), 6'b100100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule